// File: doc/BRIEF.md
# Two-Wire Serial Program/Verify Slave

This block is the device-side engine of a two-wire programming port: one externally driven serial clock and one bidirectional data line. It runs on the fast system clock, passes both pins through a two-flop synchronizer and detects serial clock edges in the system clock domain. Each transaction starts with a 6-bit command shifted in least significant bit first. Load and read commands are followed by a 16-clock frame that carries a 14-bit word between a 0 start bit and a 0 stop bit.

The engine does not own the memory or the address counter. It emits one-cycle strobes that step the address or move it to the configuration base, holds the loaded word with a pending flag, raises a programming-active level between a valid begin and an end command, and sequences a self-timed bulk erase: user memory first, then configuration memory. Reading code protection back as cleared after an erase is left to the memory. It drives the data pin's output enable with the required turn-around timing. The mode-enable input stands in for high-voltage entry detection. Dropping it aborts any partial command or frame and returns the engine to idle.

Top module: `sprog_slave`

## Requirements
- R1: After reset every output is 0: output enable, data out, loaded word, pending flag, both address strobes, programming-active, both erase phases and the error flag.
- R2: A command is 6 bits, one bit per synchronized falling edge of the serial clock, least significant bit first. Only bits [3:0] select the operation and bits [5:4] are ignored.
- R3: Code 4'b0110 (increment) raises `addr_step` for exactly one system clock cycle and has no other effect.
- R4: Code 4'b0010 (load data) is followed by a 16-clock frame. Data bit i is captured on the falling edge of frame clock i+2, for i from 0 to 13. After the 16th falling edge `load_word` holds the word and `load_pend` is 1.
- R5: Code 4'b0000 (load configuration) is followed by a 16-clock frame whose data is discarded, so `load_word` is unchanged. After the 16th falling edge `addr_to_cfg` pulses for one cycle.
- R6: Code 4'b0100 (read) samples `rd_word` when the command completes. On frame rising edge i+2 the engine enables the output and drives data bit i, for i from 0 to 13. The output enable is 0 during frame clocks 1 and 16 and returns to 0 on the 16th rising edge.
- R7: Code 4'b1000 (begin) with a pending word sets `prog_active` and clears `load_pend`. Code 4'b1110 (end) clears `prog_active`.
- R8: Code 4'b1000 with no pending word leaves `prog_active` unchanged and sets the sticky `seq_err`.
- R9: Code 4'b1001 (bulk erase) raises `erase_user` for ERASE_CYCLES/2 cycles, then `erase_cfg` for ERASE_CYCLES/2 cycles. The two are never high together.
- R10: While an erase is in progress, serial clock edges are ignored, so a command sent then has no effect.
- R11: While `mode_en` is 0, serial edges are ignored. Output enable, pending, programming-active, erase and error state are cleared, and a partial command or frame is discarded. `load_word` is retained. `mode_en` taking effect in the cycle of a frame's last falling edge cancels that frame's commit.
- R12: The remaining low-nibble codes (for example 4'b0101) are ignored and no frame follows them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| mode_en | input | 1 | Program/verify mode enable (system clock domain) |
| pgm_clk | input | 1 | Serial clock pin, asynchronous |
| pgm_dat_in | input | 1 | Serial data pin, input side, asynchronous |
| pgm_dat_out | output | 1 | Serial data pin, output value |
| pgm_dat_oe | output | 1 | Serial data pin output enable |
| rd_word | input | DW | Memory word at the current address |
| load_word | output | DW | Last word loaded by a load data frame |
| load_pend | output | 1 | A loaded word awaits a begin command |
| addr_to_cfg | output | 1 | One-cycle strobe: set the address to the configuration base |
| addr_step | output | 1 | One-cycle strobe: increment the address |
| prog_active | output | 1 | Programming in progress |
| erase_user | output | 1 | Erase phase for user memory |
| erase_cfg | output | 1 | Erase phase for configuration memory |
| seq_err | output | 1 | Sticky: begin was issued with no loaded word |

## Verification
Two functions meet in one cycle when the frame-commit edge (the synchronized 16th falling edge of a load frame) and the loss of `mode_en` arrive together. The bench drops `mode_en` exactly two system clock cycles after it lowers the serial clock for the last frame clock, so both reach the sequencer at the same clock edge. The abort must win: the behavioural reference model and a direct check both expect `load_word` to keep its old value and `load_pend` to stay 0, and a fresh load afterwards must work normally.

// File: rtl/sprog_pkg.sv
package sprog_pkg;
  // Operation codes in the low nibble of the 6-bit command (R2)
  localparam logic [3:0] OP_LDCFG  = 4'b0000;
  localparam logic [3:0] OP_LDDATA = 4'b0010;
  localparam logic [3:0] OP_READ   = 4'b0100;
  localparam logic [3:0] OP_INC    = 4'b0110;
  localparam logic [3:0] OP_BEGIN  = 4'b1000;
  localparam logic [3:0] OP_ERASE  = 4'b1001;
  localparam logic [3:0] OP_END    = 4'b1110;

  typedef enum logic {PH_CMD, PH_FRAME} phase_e;
  typedef enum logic [1:0] {FK_CFG, FK_LOAD, FK_READ} fkind_e;
endpackage

// File: rtl/sprog_sync.sv
module sprog_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/sprog_edge.sv
module sprog_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prv_q <= 1'b0;
    else        prv_q <= lvl;
  end

  assign rise = en &  lvl & ~prv_q;
  assign fall = en & ~lvl &  prv_q;
endmodule

// File: rtl/sprog_erase_timer.sv
module sprog_erase_timer #(
  parameter int CYCLES = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic go,
  output logic busy,
  output logic ph_user,
  output logic ph_cfg
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] FULL = CW'(CYCLES);
  localparam logic [CW-1:0] HALF = CW'(CYCLES / 2);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                cnt_d = '0;
    else if (go)            cnt_d = FULL;
    else if (cnt_q != '0)   cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // User memory is erased first, configuration memory second (R9)
  assign busy    = (cnt_q != '0);
  assign ph_user = (cnt_q > HALF);
  assign ph_cfg  = busy && (cnt_q <= HALF);
endmodule

// File: rtl/sprog_seq.sv
module sprog_seq
  import sprog_pkg::*;
#(
  parameter int DW    = 14,
  parameter int CMD_W = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_en,
  input  logic          clk_rise,
  input  logic          clk_fall,
  input  logic          din,
  input  logic          erase_busy,
  input  logic [DW-1:0] rd_word,
  output logic          oe,
  output logic          dout,
  output logic [DW-1:0] load_word,
  output logic          load_pend,
  output logic          addr_cfg,
  output logic          addr_step,
  output logic          prog_active,
  output logic          seq_err,
  output logic          erase_go
);
  localparam int FRAME_CLKS = DW + 2;
  localparam int MAXCNT     = (FRAME_CLKS > CMD_W) ? FRAME_CLKS : CMD_W;
  localparam int CW         = $clog2(MAXCNT + 1);
  localparam logic [CW-1:0] FIRST_C = CW'(2);
  localparam logic [CW-1:0] LAST_C  = CW'(DW + 1);
  localparam logic [CW-1:0] FRAME_C = CW'(FRAME_CLKS);
  localparam logic [CW-1:0] CMDL_C  = CW'(CMD_W - 1);

  phase_e        ph_q, ph_d;
  fkind_e        kind_q, kind_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CMD_W-1:0] cmd_q, cmd_d, cmd_full;
  logic [DW-1:0] sh_q, sh_d, word_q, word_d;
  logic pend_q, pend_d, oe_q, oe_d, dout_q, dout_d;
  logic act_q, act_d, err_q, err_d, cfg_q, cfg_d, step_q, step_d;

  assign cmd_full = {din, cmd_q[CMD_W-1:1]};  // LSb first (R2)

  always_comb begin
    ph_d = ph_q;  kind_d = kind_q;  cnt_d = cnt_q;  cmd_d = cmd_q;
    sh_d = sh_q;  word_d = word_q;  pend_d = pend_q;
    oe_d = oe_q;  dout_d = dout_q;  act_d = act_q;  err_d = err_q;
    cfg_d = 1'b0; step_d = 1'b0;    erase_go = 1'b0;
    if (!mode_en) begin
      // Abort and clear; the loaded word is kept (R11)
      ph_d = PH_CMD;  kind_d = FK_CFG;  cnt_d = '0;  cmd_d = '0;  sh_d = '0;
      pend_d = 1'b0;  oe_d = 1'b0;  dout_d = 1'b0;  act_d = 1'b0;  err_d = 1'b0;
    end else if (ph_q == PH_CMD) begin
      if (clk_fall && !erase_busy) begin   // edges ignored during erase (R10)
        cmd_d = cmd_full;
        if (cnt_q == CMDL_C) begin
          cnt_d = '0;
          cmd_d = '0;
          case (cmd_full[3:0])
            OP_LDCFG:  begin ph_d = PH_FRAME; kind_d = FK_CFG;  end
            OP_LDDATA: begin ph_d = PH_FRAME; kind_d = FK_LOAD; end
            OP_READ:   begin ph_d = PH_FRAME; kind_d = FK_READ; sh_d = rd_word; end
            OP_INC:    step_d = 1'b1;
            OP_BEGIN:  begin
              if (pend_q) begin act_d = 1'b1; pend_d = 1'b0; end
              else        err_d = 1'b1;       // load-before-program rule (R8)
            end
            OP_END:    act_d = 1'b0;
            OP_ERASE:  erase_go = 1'b1;
            default:   ;                       // unassigned codes (R12)
          endcase
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
    end else begin
      if (clk_rise) begin
        cnt_d = cnt_q + CW'(1);
        if (kind_q == FK_READ) begin
          if (cnt_d >= FIRST_C && cnt_d <= LAST_C) begin
            oe_d   = 1'b1;
            dout_d = sh_q[0];
            sh_d   = sh_q >> 1;
          end
          if (cnt_d == FRAME_C) oe_d = 1'b0;   // release on last rise (R6)
        end
      end else if (clk_fall) begin
        if (kind_q == FK_LOAD && cnt_q >= FIRST_C && cnt_q <= LAST_C)
          sh_d = {din, sh_q[DW-1:1]};
        if (cnt_q == FRAME_C) begin
          ph_d  = PH_CMD;
          cnt_d = '0;
          if (kind_q == FK_LOAD) begin word_d = sh_q; pend_d = 1'b1; end
          if (kind_q == FK_CFG)  cfg_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_CMD;  kind_q <= FK_CFG;  cnt_q <= '0;  cmd_q <= '0;
      sh_q <= '0;  word_q <= '0;  pend_q <= 1'b0;  oe_q <= 1'b0;  dout_q <= 1'b0;
      act_q <= 1'b0;  err_q <= 1'b0;  cfg_q <= 1'b0;  step_q <= 1'b0;
    end else begin
      ph_q <= ph_d;  kind_q <= kind_d;  cnt_q <= cnt_d;  cmd_q <= cmd_d;
      sh_q <= sh_d;  word_q <= word_d;  pend_q <= pend_d;  oe_q <= oe_d;  dout_q <= dout_d;
      act_q <= act_d;  err_q <= err_d;  cfg_q <= cfg_d;  step_q <= step_d;
    end
  end

  assign oe          = oe_q;
  assign dout        = dout_q;
  assign load_word   = word_q;
  assign load_pend   = pend_q;
  assign addr_cfg    = cfg_q;
  assign addr_step   = step_q;
  assign prog_active = act_q;
  assign seq_err     = err_q;
endmodule

// File: rtl/sprog_slave.sv
module sprog_slave #(
  parameter int DW           = 14,
  parameter int ERASE_CYCLES = 48,
  parameter int SYNC_STAGES  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_en,
  input  logic          pgm_clk,
  input  logic          pgm_dat_in,
  output logic          pgm_dat_out,
  output logic          pgm_dat_oe,
  input  logic [DW-1:0] rd_word,
  output logic [DW-1:0] load_word,
  output logic          load_pend,
  output logic          addr_to_cfg,
  output logic          addr_step,
  output logic          prog_active,
  output logic          erase_user,
  output logic          erase_cfg,
  output logic          seq_err
);
  logic [1:0] pins_s;
  logic       s_rise, s_fall, er_busy, er_go;

  sprog_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({pgm_dat_in, pgm_clk}), .q(pins_s)
  );

  sprog_edge u_edge (
    .clk(clk), .rst_n(rst_n), .en(mode_en), .lvl(pins_s[0]),
    .rise(s_rise), .fall(s_fall)
  );

  sprog_erase_timer #(.CYCLES(ERASE_CYCLES)) u_erase (
    .clk(clk), .rst_n(rst_n), .clr(!mode_en), .go(er_go),
    .busy(er_busy), .ph_user(erase_user), .ph_cfg(erase_cfg)
  );

  sprog_seq #(.DW(DW), .CMD_W(6)) u_seq (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en),
    .clk_rise(s_rise), .clk_fall(s_fall), .din(pins_s[1]),
    .erase_busy(er_busy), .rd_word(rd_word),
    .oe(pgm_dat_oe), .dout(pgm_dat_out),
    .load_word(load_word), .load_pend(load_pend),
    .addr_cfg(addr_to_cfg), .addr_step(addr_step),
    .prog_active(prog_active), .seq_err(seq_err), .erase_go(er_go)
  );
endmodule

// File: rtl/sprog_slave_chk.sv
module sprog_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic mode_en,
  input logic pgm_dat_oe,
  input logic load_pend,
  input logic addr_to_cfg,
  input logic addr_step,
  input logic prog_active,
  input logic erase_user,
  input logic erase_cfg,
  input logic seq_err
);
  p_step_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_step |=> !addr_step);

  p_strobes_apart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_step && addr_to_cfg));

  p_start_consumes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_active) |-> !load_pend);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(seq_err) && $past(mode_en)) |-> seq_err);

  p_erase_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(erase_user && erase_cfg));

  p_erase_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(erase_user) && $past(mode_en)) |-> erase_cfg);

  p_quiet_in_erase_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_user || erase_cfg) |-> !(addr_step || addr_to_cfg));

  p_abort_releases_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> !(pgm_dat_oe || prog_active || load_pend));
endmodule

bind sprog_slave sprog_slave_chk chk_i (.*);

// File: tb/sprog_slave_tb_top.sv
module sprog_slave_tb_top;
  localparam int DW     = 14;
  localparam int NERASE = 200;
  localparam int HB     = 4;
  localparam int LIMIT  = 150000;

  logic clk = 1'b0;
  logic rst_n, mode_en, pgm_clk, pgm_dat_in;
  logic [DW-1:0] rd_word;
  logic pgm_dat_out, pgm_dat_oe, load_pend, addr_to_cfg, addr_step;
  logic prog_active, erase_user, erase_cfg, seq_err;
  logic [DW-1:0] load_word;

  always #4 clk = ~clk;  // 125 MHz

  sprog_slave #(.DW(DW), .ERASE_CYCLES(NERASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .pgm_clk(pgm_clk),
    .pgm_dat_in(pgm_dat_in), .pgm_dat_out(pgm_dat_out), .pgm_dat_oe(pgm_dat_oe),
    .rd_word(rd_word), .load_word(load_word), .load_pend(load_pend),
    .addr_to_cfg(addr_to_cfg), .addr_step(addr_step), .prog_active(prog_active),
    .erase_user(erase_user), .erase_cfg(erase_cfg), .seq_err(seq_err)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int rd_of(input int a);
    return (a * 613 + 77) & 16'h3FFF;
  endfunction

  // ---------------- behavioural reference model ----------------
  int pc[3], pd[3];                  // pin latency queue
  int started, mph, nb, cmdv, kind, rdv, capv, m_addr;
  int e_oe, e_out, e_word, e_pend, e_cfg, e_step, e_prog, e_err, e_left;

  always @(posedge clk) begin : model
    int fall, rise, din, busy, code;
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin pc[i] = 0; pd[i] = 0; end
      started = 0; mph = 0; nb = 0; cmdv = 0; kind = 0; rdv = 0; capv = 0; m_addr = 0;
      e_oe = 0; e_out = 0; e_word = 0; e_pend = 0; e_cfg = 0; e_step = 0;
      e_prog = 0; e_err = 0; e_left = 0;
    end else begin
      started = 1;
      fall = (pc[2] == 1 && pc[1] == 0) ? 1 : 0;
      rise = (pc[2] == 0 && pc[1] == 1) ? 1 : 0;
      din  = pd[1];
      pc[2] = pc[1]; pc[1] = pc[0]; pc[0] = int'(pgm_clk);
      pd[2] = pd[1]; pd[1] = pd[0]; pd[0] = int'(pgm_dat_in);
      e_cfg = 0; e_step = 0;
      busy = (e_left > 0) ? 1 : 0;
      if (!mode_en) begin
        mph = 0; nb = 0; cmdv = 0; e_oe = 0; e_pend = 0; e_prog = 0; e_err = 0; e_left = 0;
      end else begin
        if (busy) e_left--;
        if (mph == 0) begin
          if (fall && !busy) begin
            cmdv = cmdv | (din << nb);
            nb++;
            if (nb == 6) begin
              code = cmdv & 15; nb = 0; cmdv = 0;
              if (code == 0)  begin mph = 1; kind = 0; capv = 0; end
              if (code == 2)  begin mph = 1; kind = 1; capv = 0; end
              if (code == 4)  begin mph = 1; kind = 2; rdv = int'(rd_word); end
              if (code == 6)  e_step = 1;
              if (code == 8)  begin if (e_pend) begin e_prog = 1; e_pend = 0; end else e_err = 1; end
              if (code == 9)  e_left = NERASE;
              if (code == 14) e_prog = 0;
            end
          end
        end else begin
          if (rise) begin
            nb++;
            if (kind == 2 && nb >= 2 && nb <= DW + 1) begin e_oe = 1; e_out = (rdv >> (nb - 2)) & 1; end
            if (kind == 2 && nb == DW + 2) e_oe = 0;
          end else if (fall) begin
            if (kind == 1 && nb >= 2 && nb <= DW + 1) capv = capv | (din << (nb - 2));
            if (nb == DW + 2) begin
              mph = 0; nb = 0;
              if (kind == 1) begin e_word = capv; e_pend = 1; end
              if (kind == 0) e_cfg = 1;
            end
          end
        end
      end
      if (e_cfg)  m_addr = 16'h2000;
      if (e_step) m_addr = m_addr + 1;
    end
  end

  // ---------------- per-cycle comparison and observers ----------------
  int steps_seen = 0, cfg_seen = 0, user_cyc = 0, cfgph_cyc = 0, order_bad = 0;

  always @(negedge clk) begin
    if (started == 1) begin
      chk("R6", "data oe", int'(pgm_dat_oe), e_oe);
      if (e_oe == 1) chk("R6", "data out", int'(pgm_dat_out), e_out);
      chk("R4", "load_word", int'(load_word), e_word);
      chk("R4", "load_pend", int'(load_pend), e_pend);
      chk("R5", "addr_to_cfg", int'(addr_to_cfg), e_cfg);
      chk("R3", "addr_step", int'(addr_step), e_step);
      chk("R7", "prog_active", int'(prog_active), e_prog);
      chk("R8", "seq_err", int'(seq_err), e_err);
      chk("R9", "erase_user", int'(erase_user), (e_left > NERASE / 2) ? 1 : 0);
      chk("R9", "erase_cfg", int'(erase_cfg), (e_left > 0 && e_left <= NERASE / 2) ? 1 : 0);
      steps_seen += int'(addr_step);
      cfg_seen   += int'(addr_to_cfg);
      user_cyc   += int'(erase_user);
      cfgph_cyc  += int'(erase_cfg);
      if (erase_cfg && user_cyc < NERASE / 2) order_bad++;
    end
    rd_word = DW'(rd_of(m_addr));
  end

  // ---------------- stimulus tasks ----------------
  task automatic pulse(input logic d, output logic o, output logic e);
    @(negedge clk);
    pgm_dat_in = d; pgm_clk = 1'b1;
    repeat (HB) @(negedge clk);
    o = pgm_dat_out; e = pgm_dat_oe;
    pgm_clk = 1'b0;
    repeat (HB) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [5:0] c);
    logic o, e;
    for (int i = 0; i < 6; i++) pulse(c[i], o, e);
    repeat (6) @(negedge clk);
  endtask

  task automatic send_frame(input logic [DW-1:0] w, input bit abort_last,
                            output logic [DW-1:0] got, output logic [DW+1:0] oe_mask);
    logic o, e;
    logic [DW+1:0] fr;
    fr = {1'b0, w, 1'b0};
    got = '0; oe_mask = '0;
    for (int k = 0; k < DW + 2; k++) begin
      if (abort_last && k == DW + 1) begin
        @(negedge clk);
        pgm_dat_in = 1'b0; pgm_clk = 1'b1;
        repeat (HB) @(negedge clk);
        pgm_clk = 1'b0;
        repeat (2) @(negedge clk);   // commit edge and mode loss meet here
        mode_en = 1'b0;
        repeat (6) @(negedge clk);
        mode_en = 1'b1;
        repeat (2) @(negedge clk);
      end else begin
        pulse(fr[k], o, e);
        oe_mask[k] = e;
        if (k >= 1 && k <= DW) got[k-1] = o;
      end
    end
    repeat (6) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  int cyc = 0;
  bit done = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == LIMIT && !done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- directed sequence ----------------
  initial begin
    logic [DW-1:0] got;
    logic [DW+1:0] msk;
    rst_n = 1'b0; mode_en = 1'b0; pgm_clk = 1'b0; pgm_dat_in = 1'b0; rd_word = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "oe", int'(pgm_dat_oe), 0);
    chk("R1", "out", int'(pgm_dat_out), 0);
    chk("R1", "word", int'(load_word), 0);
    chk("R1", "flags", int'({load_pend, addr_to_cfg, addr_step, prog_active,
                             erase_user, erase_cfg, seq_err}), 0);
    mode_en = 1'b1;
    repeat (4) @(negedge clk);

    // R4: load data
    send_cmd(6'b000010);
    send_frame(14'h2A5C, 0, got, msk);
    chk("R4", "loaded word", int'(load_word), 'h2A5C);
    chk("R4", "pending", int'(load_pend), 1);
    chk("R4", "no oe during load", int'(msk), 0);

    // R2/R3: increment with upper bits set
    send_cmd(6'b110110);
    chk("R2", "upper bits ignored, step count", steps_seen, 1);

    // R7: begin then end
    send_cmd(6'b001000);
    chk("R7", "active after begin", int'(prog_active), 1);
    chk("R7", "pending consumed", int'(load_pend), 0);
    send_cmd(6'b001110);
    chk("R7", "inactive after end", int'(prog_active), 0);

    // R8: begin without load
    send_cmd(6'b001000);
    chk("R8", "error set", int'(seq_err), 1);
    chk("R8", "still inactive", int'(prog_active), 0);

    // R12: unassigned code
    send_cmd(6'b000101);
    repeat (20) @(negedge clk);
    chk("R12", "steps unchanged", steps_seen, 1);
    chk("R12", "cfg unchanged", cfg_seen, 0);
    chk("R12", "word unchanged", int'(load_word), 'h2A5C);
    chk("R12", "oe idle", int'(pgm_dat_oe), 0);

    // R6: read at address 1
    send_cmd(6'b000100);
    send_frame('0, 0, got, msk);
    chk("R6", "read word", int'(got), rd_of(1));
    chk("R6", "oe window", int'(msk), 'h7FFE);

    // R5: load configuration discards data
    send_cmd(6'b000000);
    send_frame(14'h1555, 0, got, msk);
    chk("R5", "cfg strobes", cfg_seen, 1);
    chk("R5", "word kept", int'(load_word), 'h2A5C);

    // R9/R10: erase, with an increment sent while busy
    send_cmd(6'b001001);
    send_cmd(6'b000110);
    chk("R10", "busy during ignored cmd", int'(erase_user | erase_cfg), 1);
    repeat (NERASE + 20) @(negedge clk);
    chk("R10", "steps unchanged", steps_seen, 1);
    chk("R9", "user phase cycles", user_cyc, NERASE / 2);
    chk("R9", "cfg phase cycles", cfgph_cyc, NERASE / 2);
    chk("R9", "phase order", order_bad, 0);

    // R11: mode loss in the commit cycle of a load frame
    send_cmd(6'b000010);
    send_frame(14'h0ABC, 0, got, msk);
    chk("R11", "setup word", int'(load_word), 'h0ABC);
    send_cmd(6'b000010);
    send_frame(14'h1234, 1, got, msk);
    chk("R11", "aborted frame not committed", int'(load_word), 'h0ABC);
    chk("R11", "pending cleared", int'(load_pend), 0);
    chk("R11", "error cleared", int'(seq_err), 0);
    send_cmd(6'b000010);
    send_frame(14'h1234, 0, got, msk);
    chk("R11", "recovery load", int'(load_word), 'h1234);
    chk("R11", "recovery pending", int'(load_pend), 1);

    // R11: edges ignored while mode is low
    mode_en = 1'b0;
    send_cmd(6'b000110);
    mode_en = 1'b1;
    repeat (10) @(negedge clk);
    chk("R11", "no step while mode low", steps_seen, 1);
    send_cmd(6'b000110);
    chk("R3", "step after mode return", steps_seen, 2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule